// File: doc/BRIEF.md
# Arm and Emergency-Stop Command Controller

This block sits after a command receiver that has already framed a message and checked its integrity. It takes one command per cycle, as a type byte, a length byte and a packed payload. It owns the control state of a drive system: whether the system is armed, whether an emergency stop is latched, the current signed speed and steer setpoints, a set of three gain words, and the millisecond time of the last heartbeat. The time comes from a free-running counter outside the block.

Every recognised command gets exactly one response, one cycle later. The response is either an acknowledge carrying the command type, or a negative acknowledge carrying the command type and an error code. A command's checks run in a fixed order. For a drive command that order is length, then emergency stop, then armed. The first check that fails chooses the error. A command that is refused leaves all state unchanged.

Top module: `arm_stop_ctrl`

## Requirements
- R1: After reset the block is disarmed, the stop is clear, speed, steer, heartbeat time and all gain words are zero, the gain-updated flag is low and no response is valid.
- R2: A heartbeat command (type 0x01) stores the ms_time value present at the command into hb_time and is acknowledged.
- R3: A drive command (type 0x02) with fewer than 4 payload bytes is answered with error 1. This check comes before every other drive check, and no state changes.
- R4: A drive command with enough bytes is answered with error 3 while the stop is latched, or else with error 4 while disarmed. In both cases no state changes.
- R5: An accepted drive command loads speed from payload bytes 0 and 1 and steer from bytes 2 and 3. Both are big-endian, with byte k at cmd_payload bits 8k+7:8k. The command also stamps hb_time and is acknowledged.
- R6: A stop command (type 0x03) with no payload is answered with error 1. Otherwise a nonzero byte 0 latches the stop and zeroes speed and steer, a zero byte 0 clears the stop, the armed state is left as it is, and the command is acknowledged.
- R7: An arm command (type 0x04) with no payload is answered with error 1. A nonzero byte 0 while the stop is latched is answered with error 3 and changes nothing. Otherwise byte 0 nonzero arms and zero disarms, disarming zeroes speed and steer, and the command is acknowledged.
- R8: A gain command (type 0x05) with fewer than 12 bytes is answered with error 1. Otherwise bytes 0-3, 4-7 and 8-11 load gain_p, gain_i and gain_d as big-endian words. The gain-updated flag is then set and stays set, and the command is acknowledged.
- R9: A command of any other type produces no response and changes no state.
- R10: A response is valid exactly one cycle after the command. An acknowledge has rsp_nack low, rsp_cmd equal to the command type and rsp_err 0. A negative acknowledge has rsp_nack high, rsp_cmd equal to the command type and rsp_err equal to the error code (1 bad length, 2 reserved for integrity failures upstream, 3 stop active, 4 disarmed).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_type | input | 8 | Command type code |
| cmd_len | input | 8 | Payload length in bytes |
| cmd_payload | input | 96 | Payload, byte k at bits 8k+7:8k |
| ms_time | input | 32 | Free-running millisecond time |
| rsp_valid | output | 1 | Response valid |
| rsp_nack | output | 1 | Response is a negative acknowledge |
| rsp_cmd | output | 8 | Type of the command answered |
| rsp_err | output | 8 | Error code, 0 on acknowledge |
| armed | output | 1 | Armed state |
| stop_active | output | 1 | Emergency stop latched |
| speed | output | 16 | Signed speed setpoint |
| steer | output | 16 | Signed steer setpoint |
| hb_time | output | 32 | Time of last heartbeat or accepted drive |
| gain_p | output | 32 | First gain word |
| gain_i | output | 32 | Second gain word |
| gain_d | output | 32 | Third gain word |
| gain_updated | output | 1 | Gain words have been loaded since reset |

## Verification
A wrong armed or stop flag first shows up in the response to the next drive or arm command, as an error code that is out of order or missing. It also shows directly on the armed and stop_active ports one cycle after the command that corrupted it. If setpoint clearing breaks, a nonzero speed or steer remains visible in the cycle after a stop or disarm. A misordered check shows up as the wrong error code on the response that follows. Each command in the sequence is followed by a comparison of every state port, so a fault is caught within two cycles of the command that causes it.

// File: rtl/asc_pkg.sv
package asc_pkg;
  localparam logic [7:0] CT_HEARTBEAT = 8'h01;
  localparam logic [7:0] CT_DRIVE     = 8'h02;
  localparam logic [7:0] CT_STOP      = 8'h03;
  localparam logic [7:0] CT_ARM       = 8'h04;
  localparam logic [7:0] CT_GAIN      = 8'h05;

  typedef enum logic [7:0] {
    ERR_NONE     = 8'd0,
    ERR_LEN      = 8'd1,
    ERR_CRC      = 8'd2,
    ERR_STOP     = 8'd3,
    ERR_DISARMED = 8'd4
  } err_e;

  // decoded outcome of one command
  typedef struct packed {
    logic respond;
    logic nack;
    err_e err;
    logic stamp_hb;
    logic load_drive;
    logic stop_we;
    logic stop_val;
    logic arm_we;
    logic arm_val;
    logic zero_sp;
    logic load_gain;
  } action_t;
endpackage

// File: rtl/asc_decode.sv
module asc_decode
  import asc_pkg::*;
#(
  parameter int SP_BYTES   = 2,
  parameter int GAIN_BYTES = 4
) (
  input  logic       cmd_valid,
  input  logic [7:0] cmd_type,
  input  logic [7:0] cmd_len,
  input  logic [7:0] first_byte,
  input  logic       stop_q,
  input  logic       armed_q,
  output action_t    act
);
  localparam logic [7:0] DRIVE_MIN = 8'(2 * SP_BYTES);
  localparam logic [7:0] GAIN_MIN  = 8'(3 * GAIN_BYTES);

  logic req_on;
  assign req_on = (first_byte != 8'd0);

  always_comb begin
    act     = '0;
    act.err = ERR_NONE;
    if (cmd_valid) begin
      case (cmd_type)
        CT_HEARTBEAT: begin
          act.respond  = 1'b1;
          act.stamp_hb = 1'b1;
        end
        CT_DRIVE: begin
          act.respond = 1'b1;
          if (cmd_len < DRIVE_MIN) begin
            act.nack = 1'b1; act.err = ERR_LEN;
          end else if (stop_q) begin
            act.nack = 1'b1; act.err = ERR_STOP;
          end else if (!armed_q) begin
            act.nack = 1'b1; act.err = ERR_DISARMED;
          end else begin
            act.load_drive = 1'b1;
            act.stamp_hb   = 1'b1;
          end
        end
        CT_STOP: begin
          act.respond = 1'b1;
          if (cmd_len == 8'd0) begin
            act.nack = 1'b1; act.err = ERR_LEN;
          end else begin
            act.stop_we  = 1'b1;
            act.stop_val = req_on;
            act.zero_sp  = req_on;
          end
        end
        CT_ARM: begin
          act.respond = 1'b1;
          if (cmd_len == 8'd0) begin
            act.nack = 1'b1; act.err = ERR_LEN;
          end else if (stop_q && req_on) begin
            act.nack = 1'b1; act.err = ERR_STOP;
          end else begin
            act.arm_we  = 1'b1;
            act.arm_val = req_on;
            act.zero_sp = !req_on;
          end
        end
        CT_GAIN: begin
          act.respond = 1'b1;
          if (cmd_len < GAIN_MIN) begin
            act.nack = 1'b1; act.err = ERR_LEN;
          end else begin
            act.load_gain = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/asc_state.sv
module asc_state
  import asc_pkg::*;
#(
  parameter int MAX_PAY = 12,
  parameter int TIME_W  = 32,
  parameter int SP_W    = 16,
  parameter int GAIN_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  action_t                 act,
  input  logic [MAX_PAY*8-1:0]    payload,
  input  logic [TIME_W-1:0]       ms_time,
  output logic                    armed_q,
  output logic                    stop_q,
  output logic [SP_W-1:0]         speed_q,
  output logic [SP_W-1:0]         steer_q,
  output logic [TIME_W-1:0]       hb_q,
  output logic [2:0][GAIN_W-1:0]  gain_q,
  output logic                    gain_upd_q
);
  localparam int SPB = SP_W / 8;
  localparam int GB  = GAIN_W / 8;

  logic [SP_W-1:0]        speed_in, steer_in, speed_d, steer_d;
  logic [2:0][GAIN_W-1:0] gain_in;
  logic                   armed_d, stop_d, sp_en;

  // big-endian unpacking: lowest payload byte is most significant
  for (genvar k = 0; k < SPB; k++) begin : g_sp_byte
    assign speed_in[8*(SPB-1-k) +: 8] = payload[8*k +: 8];
    assign steer_in[8*(SPB-1-k) +: 8] = payload[8*(SPB+k) +: 8];
  end
  for (genvar g = 0; g < 3; g++) begin : g_word
    for (genvar k = 0; k < GB; k++) begin : g_byte
      assign gain_in[g][8*(GB-1-k) +: 8] = payload[8*(g*GB+k) +: 8];
    end
  end

  // next-state
  always_comb begin
    armed_d = act.arm_we  ? act.arm_val  : armed_q;
    stop_d  = act.stop_we ? act.stop_val : stop_q;
    sp_en   = act.load_drive | act.zero_sp;
    speed_d = act.zero_sp ? '0 : speed_in;
    steer_d = act.zero_sp ? '0 : steer_in;
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      stop_q     <= 1'b0;
      speed_q    <= '0;
      steer_q    <= '0;
      hb_q       <= '0;
      gain_q     <= '0;
      gain_upd_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      stop_q  <= stop_d;
      if (sp_en) begin
        speed_q <= speed_d;
        steer_q <= steer_d;
      end
      if (act.stamp_hb) hb_q <= ms_time;
      if (act.load_gain) begin
        gain_q     <= gain_in;
        gain_upd_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/asc_resp.sv
module asc_resp
  import asc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  action_t    act,
  input  logic [7:0] cmd_type,
  output logic       rsp_valid,
  output logic       rsp_nack,
  output logic [7:0] rsp_cmd,
  output logic [7:0] rsp_err
);
  logic       valid_d, nack_d;
  logic [7:0] err_d;

  always_comb begin
    valid_d = act.respond;
    nack_d  = act.respond & act.nack;
    err_d   = act.nack ? 8'(act.err) : 8'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_nack  <= 1'b0;
      rsp_cmd   <= '0;
      rsp_err   <= '0;
    end else begin
      rsp_valid <= valid_d;
      if (valid_d) begin
        rsp_nack <= nack_d;
        rsp_cmd  <= cmd_type;
        rsp_err  <= err_d;
      end
    end
  end
endmodule

// File: rtl/arm_stop_ctrl.sv
module arm_stop_ctrl
  import asc_pkg::*;
#(
  parameter int MAX_PAY = 12,
  parameter int TIME_W  = 32,
  parameter int SP_W    = 16,
  parameter int GAIN_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [7:0]           cmd_type,
  input  logic [7:0]           cmd_len,
  input  logic [MAX_PAY*8-1:0] cmd_payload,
  input  logic [TIME_W-1:0]    ms_time,
  output logic                 rsp_valid,
  output logic                 rsp_nack,
  output logic [7:0]           rsp_cmd,
  output logic [7:0]           rsp_err,
  output logic                 armed,
  output logic                 stop_active,
  output logic [SP_W-1:0]      speed,
  output logic [SP_W-1:0]      steer,
  output logic [TIME_W-1:0]    hb_time,
  output logic [GAIN_W-1:0]    gain_p,
  output logic [GAIN_W-1:0]    gain_i,
  output logic [GAIN_W-1:0]    gain_d,
  output logic                 gain_updated
);
  localparam int SP_BYTES   = SP_W / 8;
  localparam int GAIN_BYTES = GAIN_W / 8;

  // reset asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  action_t                act;
  logic [2:0][GAIN_W-1:0] gain_q;

  asc_decode #(.SP_BYTES(SP_BYTES), .GAIN_BYTES(GAIN_BYTES)) u_decode (
    .cmd_valid (cmd_valid),
    .cmd_type  (cmd_type),
    .cmd_len   (cmd_len),
    .first_byte(cmd_payload[7:0]),
    .stop_q    (stop_active),
    .armed_q   (armed),
    .act       (act)
  );

  asc_state #(.MAX_PAY(MAX_PAY), .TIME_W(TIME_W), .SP_W(SP_W), .GAIN_W(GAIN_W)) u_state (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .act       (act),
    .payload   (cmd_payload),
    .ms_time   (ms_time),
    .armed_q   (armed),
    .stop_q    (stop_active),
    .speed_q   (speed),
    .steer_q   (steer),
    .hb_q      (hb_time),
    .gain_q    (gain_q),
    .gain_upd_q(gain_updated)
  );

  asc_resp u_resp (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .act      (act),
    .cmd_type (cmd_type),
    .rsp_valid(rsp_valid),
    .rsp_nack (rsp_nack),
    .rsp_cmd  (rsp_cmd),
    .rsp_err  (rsp_err)
  );

  assign gain_p = gain_q[0];
  assign gain_i = gain_q[1];
  assign gain_d = gain_q[2];
endmodule

// File: rtl/asc_check.sv
module asc_check
  import asc_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int SP_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [7:0]        cmd_type,
  input logic              rsp_valid,
  input logic [7:0]        rsp_err,
  input logic              armed,
  input logic              stop_active,
  input logic [SP_W-1:0]   speed,
  input logic [SP_W-1:0]   steer,
  input logic [TIME_W-1:0] hb_time
);
  a_r10_rsp_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd_valid));

  a_r7_no_arm_under_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> !$past(stop_active));

  a_r6_stop_clears_setpoints: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_active) |-> (speed == '0 && steer == '0));

  a_r7_disarm_clears_setpoints: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> (speed == '0 && steer == '0));

  a_r4_setpoint_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(speed) || !$stable(steer)) && (speed != '0 || steer != '0)
      |-> (armed && !stop_active));

  a_r2_hb_only_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hb_time) |-> ($past(cmd_valid) &&
      ($past(cmd_type) == CT_HEARTBEAT || $past(cmd_type) == CT_DRIVE)));

  a_r4_disarmed_err_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err == 8'd4) |-> !armed);

  a_r9_unknown_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_valid) && $past(cmd_type) != CT_HEARTBEAT && $past(cmd_type) != CT_DRIVE &&
     $past(cmd_type) != CT_STOP && $past(cmd_type) != CT_ARM && $past(cmd_type) != CT_GAIN)
      |-> !rsp_valid);
endmodule

bind arm_stop_ctrl asc_check #(.TIME_W(TIME_W), .SP_W(SP_W)) u_asc_check (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_type   (cmd_type),
  .rsp_valid  (rsp_valid),
  .rsp_err    (rsp_err),
  .armed      (armed),
  .stop_active(stop_active),
  .speed      (speed),
  .steer      (steer),
  .hb_time    (hb_time)
);

// File: tb/arm_stop_ctrl_test.sv
module arm_stop_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [7:0]  cmd_type, cmd_len;
  logic [95:0] cmd_payload;
  logic [31:0] ms_time;
  logic        rsp_valid, rsp_nack;
  logic [7:0]  rsp_cmd, rsp_err;
  logic        armed, stop_active, gain_updated;
  logic [15:0] speed, steer;
  logic [31:0] hb_time, gain_p, gain_i, gain_d;

  arm_stop_ctrl uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  logic [16:0] exp_q[$];   // {nack, cmd, err}

  // bench model
  logic        m_armed, m_stop, m_upd;
  logic [15:0] m_speed, m_steer;
  logic [31:0] m_hb, m_kp, m_ki, m_kd;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [95:0] wire_to_pay(logic [95:0] w);
    logic [95:0] p;
    for (int k = 0; k < 12; k++) p[8*k +: 8] = w[8*(11-k) +: 8];
    return p;
  endfunction

  task automatic check_state(string req);
    check(req, "armed", 32'(armed), 32'(m_armed));
    check(req, "stop", 32'(stop_active), 32'(m_stop));
    check(req, "speed", 32'(speed), 32'(m_speed));
    check(req, "steer", 32'(steer), 32'(m_steer));
    check(req, "hb_time", hb_time, m_hb);
    check(req, "gain_upd", 32'(gain_updated), 32'(m_upd));
    check(req, "gain_p", gain_p, m_kp);
    check(req, "gain_i", gain_i, m_ki);
    check(req, "gain_d", gain_d, m_kd);
  endtask

  // w: payload in wire order, first byte in bits 95:88
  task automatic send(string req, logic [7:0] t, logic [7:0] l, logic [95:0] w);
    logic       resp = 1'b1;
    logic       nk   = 1'b0;
    logic [7:0] er   = 8'd0;
    logic       on   = (w[95:88] != 8'd0);
    @(negedge clk);
    ms_time = ms_time + 32'd5;
    case (t)
      8'h01: m_hb = ms_time;
      8'h02: if (l < 4) begin nk = 1; er = 1; end
             else if (m_stop) begin nk = 1; er = 3; end
             else if (!m_armed) begin nk = 1; er = 4; end
             else begin m_speed = w[95:80]; m_steer = w[79:64]; m_hb = ms_time; end
      8'h03: if (l < 1) begin nk = 1; er = 1; end
             else begin m_stop = on; if (on) begin m_speed = 0; m_steer = 0; end end
      8'h04: if (l < 1) begin nk = 1; er = 1; end
             else if (m_stop && on) begin nk = 1; er = 3; end
             else begin m_armed = on; if (!on) begin m_speed = 0; m_steer = 0; end end
      8'h05: if (l < 12) begin nk = 1; er = 1; end
             else begin m_kp = w[95:64]; m_ki = w[63:32]; m_kd = w[31:0]; m_upd = 1; end
      default: resp = 1'b0;
    endcase
    if (resp) exp_q.push_back({nk, t, er});
    cmd_valid   = 1'b1;
    cmd_type    = t;
    cmd_len     = l;
    cmd_payload = wire_to_pay(w);
    @(negedge clk);
    cmd_valid   = 1'b0;
    cmd_payload = '1;
    check_state(req);
  endtask

  // monitor: compares each response against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R9 unexpected response: actual %h expected none",
                 {rsp_nack, rsp_cmd, rsp_err});
      end else begin
        logic [16:0] e;
        e = exp_q.pop_front();
        if ({rsp_nack, rsp_cmd, rsp_err} !== e) begin
          n_fail++;
          $display("FAIL R10 response: actual %h expected %h",
                   {rsp_nack, rsp_cmd, rsp_err}, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_type = '0; cmd_len = '0;
    cmd_payload = '0; ms_time = 32'd1000;
    m_armed = 0; m_stop = 0; m_upd = 0; m_speed = 0; m_steer = 0;
    m_hb = 0; m_kp = 0; m_ki = 0; m_kd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    check_state("R1");

    send("R2", 8'h01, 8'd0, '0);                                // heartbeat
    send("R4", 8'h02, 8'd4, {32'h0100_0200, 64'h0});            // disarmed -> 4
    send("R3", 8'h02, 8'd3, {32'h0100_0200, 64'h0});            // short -> 1
    send("R7", 8'h04, 8'd0, {8'h01, 88'h0});                    // arm no byte -> 1
    send("R7", 8'h04, 8'd1, {8'h01, 88'h0});                    // arm
    send("R5", 8'h02, 8'd4, {32'h8001_1234, 64'h0});            // drive accepted
    send("R5", 8'h02, 8'd6, {32'h7FFF_FFFE, 64'h0});            // longer payload
    send("R6", 8'h03, 8'd1, {8'h20, 88'h0});                    // stop on
    send("R4", 8'h02, 8'd4, {32'h0011_0022, 64'h0});            // stop -> 3
    send("R3", 8'h02, 8'd2, {32'h0011_0022, 64'h0});            // length first -> 1
    send("R7", 8'h04, 8'd1, {8'h01, 88'h0});                    // arm under stop -> 3
    send("R6", 8'h03, 8'd0, '0);                                // stop no byte -> 1
    send("R6", 8'h03, 8'd1, {8'h00, 88'h0});                    // stop off
    send("R5", 8'h02, 8'd4, {32'hC350_0064, 64'h0});            // drive again
    send("R7", 8'h04, 8'd1, {8'h00, 88'h0});                    // disarm clears
    send("R4", 8'h02, 8'd4, {32'h0001_0001, 64'h0});            // disarmed -> 4
    send("R7", 8'h04, 8'd1, {8'hFF, 88'h0});                    // rearm
    send("R7", 8'h04, 8'd1, {8'h00, 88'h0});                    // disarm while stop clear
    send("R6", 8'h03, 8'd1, {8'h01, 88'h0});                    // stop on
    send("R7", 8'h04, 8'd1, {8'h00, 88'h0});                    // disarm under stop ok
    send("R6", 8'h03, 8'd1, {8'h00, 88'h0});
    send("R8", 8'h05, 8'd11, {96'h3F80_0000_4000_0000_4040_0000}); // short -> 1
    send("R8", 8'h05, 8'd12, {96'h3F80_0000_4000_0000_4040_0000}); // load
    send("R8", 8'h05, 8'd12, {96'hDEAD_BEEF_0123_4567_89AB_CDEF}); // reload
    send("R9", 8'h7E, 8'd4, {32'h1111_2222, 64'h0});            // unknown
    send("R9", 8'h00, 8'd1, {8'h01, 88'h0});                    // unknown
    send("R2", 8'h01, 8'd2, '0);                                // heartbeat again

    repeat (3) @(negedge clk);
    check("R10", "pending responses", 32'(exp_q.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule